// File: doc/BRIEF.md
# Global Layer Inhibition Unit

This block supplies shared negative feedback to one layer of a spiking network. While the layer is being processed, it counts the spikes the layer emits. When the layer finishes, it scales that count by an inhibition weight and adds the result into an accumulator. At the end of each time slice, a single inhibitory potential is decayed and then raised by the accumulator. The accumulator is then emptied for the next slice.

Per-neuron inhibitory state is not kept. Instead, the block folds the global potential into the firing threshold. At the start of each layer it registers an effective threshold, equal to the static threshold plus the potential. That value stays fixed while the layer's neurons are evaluated.

A single multiplier is shared between the layer-end scaling and the slice-end decay. Each update takes two cycles, and a busy flag is raised for that time.

Top module: `gli_inhibit_unit`

## Requirements
- R1: After reset, `thresh_eff_o` is 0 and `busy_o` is 0, and the spike count, the accumulator and the potential are all 0.
- R2: Each cycle with `spike_i` high adds one to the spike count. The count stops at 2^CNT_W-1 (1023 by default) and does not wrap.
- R3: A `layer_end_i` accepted while idle does the following:
  - It takes the count of spikes seen before that cycle and adds count times `weight_i` (unsigned) into the accumulator.
  - It restarts the count; a spike in the strobe cycle counts toward the next layer.
  - `busy_o` is high for exactly the two following cycles.
- R4: A `slice_end_i` accepted while idle sets the potential to floor(potential*`decay_i`/2^DEC_FRAC) plus the accumulator, and clears the accumulator. `busy_o` is high for the two following cycles.
- R5: At slice end, decay is applied before the accumulator is added, so the newly accumulated activity is not decayed in the slice it arrives.
- R6: A `layer_start_i` accepted while idle sets `thresh_eff_o` on the next edge to the static threshold plus the potential. At all other times, `thresh_eff_o` holds its value.
- R7: `layer_start_i`, `layer_end_i` and `slice_end_i` are ignored while `busy_o` is high. If `layer_end_i` and `slice_end_i` arrive together while idle, only `layer_end_i` takes effect.
- R8: The accumulator and the potential saturate at the signed maximum 2^(POT_W-1)-1 (32767 by default) instead of wrapping.
- R9: The effective threshold sum saturates at the signed limits of POT_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spike_i | input | 1 | One spike from the layer in this cycle |
| layer_start_i | input | 1 | Strobe: latch the effective threshold for a new layer |
| layer_end_i | input | 1 | Strobe: fold the layer's spike count into the accumulator |
| slice_end_i | input | 1 | Strobe: decay the potential and add the accumulator |
| weight_i | input | WGT_W | Unsigned inhibition weight per spike |
| decay_i | input | WGT_W | Unsigned decay factor, fraction of 2^DEC_FRAC |
| thresh_static_i | input | POT_W | Signed static firing threshold |
| busy_o | output | 1 | Update in progress; strobes are ignored |
| thresh_eff_o | output | POT_W | Signed registered effective threshold |

## Verification
The timing of each result is fixed:
- `busy_o` rises on the edge that accepts `layer_end_i` or `slice_end_i`. It falls two edges later.
- The accumulator and the potential are final once `busy_o` is low again.
- `thresh_eff_o` changes on the edge right after an accepted `layer_start_i`.

The bench drives inputs on falling edges and samples on the falling edge after the relevant rising edge. Every strobe task returns only after the third falling edge, when the block is idle again. Hidden state is read out only through a later `layer_start_i`. The checks for ignored strobes sample `thresh_eff_o` both within the busy window and after it.

// File: rtl/gli_pkg.sv
`timescale 1ns/1ps
package gli_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LMUL,
        ST_LADD,
        ST_SMUL,
        ST_SADD
    } gli_state_e;
endpackage

// File: rtl/gli_spike_counter.sv
`timescale 1ns/1ps
module gli_spike_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = inc_i ? CNT_W'(1) : '0;
        end else if (inc_i && (cnt_q != CMAX)) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    AST_CNT_HOLD_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CMAX && inc_i && !clr_i) |=> (cnt_q == CMAX)); // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !inc_i) |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/gli_shared_mult.sv
`timescale 1ns/1ps
module gli_shared_mult #(
    parameter int A_W = 16,
    parameter int B_W = 8
) (
    input  logic signed [A_W-1:0]   a_i,
    input  logic        [B_W-1:0]   b_i,
    output logic signed [A_W+B_W:0] p_o
);
    logic signed [A_W+B_W:0] a_ext;
    logic signed [A_W+B_W:0] b_ext;

    always_comb begin
        a_ext = (A_W+B_W+1)'(a_i);
        b_ext = $signed((A_W+B_W+1)'(b_i));
        p_o   = a_ext * b_ext;
    end
endmodule

// File: rtl/gli_inhibit_unit.sv
`timescale 1ns/1ps
module gli_inhibit_unit
    import gli_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int WGT_W    = 8,
    parameter int POT_W    = 16,
    parameter int DEC_FRAC = WGT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    spike_i,
    input  logic                    layer_start_i,
    input  logic                    layer_end_i,
    input  logic                    slice_end_i,
    input  logic        [WGT_W-1:0] weight_i,
    input  logic        [WGT_W-1:0] decay_i,
    input  logic signed [POT_W-1:0] thresh_static_i,
    output logic                    busy_o,
    output logic signed [POT_W-1:0] thresh_eff_o
);
    localparam int A_W = (CNT_W + 1 > POT_W) ? CNT_W + 1 : POT_W;
    localparam int P_W = A_W + WGT_W + 1;
    localparam int E_W = P_W + 1;

    typedef logic signed [POT_W-1:0] pot_t;
    typedef logic signed [E_W-1:0]   wide_t;

    localparam pot_t  POT_MAX  = {1'b0, {(POT_W-1){1'b1}}};
    localparam pot_t  POT_MIN  = {1'b1, {(POT_W-1){1'b0}}};
    localparam wide_t WIDE_MAX = wide_t'(POT_MAX);
    localparam wide_t WIDE_MIN = wide_t'(POT_MIN);

    typedef struct packed {
        gli_state_e       state;
        logic [CNT_W-1:0] snap;
        pot_t             prod;
        pot_t             acc;
        pot_t             pot;
        pot_t             thr;
    } regs_t;

    function automatic pot_t sat_pot(input wide_t v);
        if (v > WIDE_MAX)      return POT_MAX;
        else if (v < WIDE_MIN) return POT_MIN;
        else                   return pot_t'(v);
    endfunction

    regs_t r_d, r_q;

    logic [CNT_W-1:0]        cnt;
    logic                    cnt_clr;
    logic signed [A_W-1:0]   mul_a;
    logic [WGT_W-1:0]        mul_b;
    logic signed [P_W-1:0]   mul_p;
    logic signed [P_W-1:0]   mul_shr;

    gli_spike_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (spike_i),
        .clr_i (cnt_clr),
        .cnt_o (cnt)
    );

    // One multiplier: count*weight for a layer, potential*decay for a slice
    always_comb begin
        if (r_q.state == ST_SMUL) begin
            mul_a = A_W'(r_q.pot);
            mul_b = decay_i;
        end else begin
            mul_a = $signed(A_W'(r_q.snap));
            mul_b = weight_i;
        end
    end

    gli_shared_mult #(.A_W(A_W), .B_W(WGT_W)) u_mult (
        .a_i (mul_a),
        .b_i (mul_b),
        .p_o (mul_p)
    );

    assign mul_shr = mul_p >>> DEC_FRAC;

    always_comb begin
        r_d     = r_q;
        cnt_clr = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (layer_end_i) begin
                    r_d.snap  = cnt;
                    cnt_clr   = 1'b1;
                    r_d.state = ST_LMUL;
                end else if (slice_end_i) begin
                    r_d.state = ST_SMUL;
                end
                if (layer_start_i) begin
                    r_d.thr = sat_pot(wide_t'(thresh_static_i) + wide_t'(r_q.pot));
                end
            end
            ST_LMUL: begin
                r_d.prod  = sat_pot(wide_t'(mul_p));
                r_d.state = ST_LADD;
            end
            ST_LADD: begin
                r_d.acc   = sat_pot(wide_t'(r_q.acc) + wide_t'(r_q.prod));
                r_d.state = ST_IDLE;
            end
            ST_SMUL: begin
                r_d.prod  = pot_t'(mul_shr);
                r_d.state = ST_SADD;
            end
            ST_SADD: begin
                r_d.pot   = sat_pot(wide_t'(r_q.prod) + wide_t'(r_q.acc));
                r_d.acc   = '0;
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.snap  <= '0;
            r_q.prod  <= '0;
            r_q.acc   <= '0;
            r_q.pot   <= '0;
            r_q.thr   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o       = (r_q.state != ST_IDLE);
    assign thresh_eff_o = r_q.thr;

    AST_THR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(layer_start_i && !busy_o) |=> $stable(thresh_eff_o)); // R6
    AST_BUSY_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |=> busy_o); // R3
    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |=> !busy_o); // R3
    AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SADD) |=> (r_q.acc == '0)); // R4
    AST_POT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SADD) |=> (r_q.pot >= $past(r_q.acc))); // R8
    AST_POT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != ST_SADD) |=> $stable(r_q.pot)); // R7
endmodule

// File: tb/gli_inhibit_unit_tb.sv
`timescale 1ns/1ps
module gli_inhibit_unit_tb;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               spike_i = 1'b0;
    logic               layer_start_i = 1'b0;
    logic               layer_end_i = 1'b0;
    logic               slice_end_i = 1'b0;
    logic        [7:0]  weight_i = '0;
    logic        [7:0]  decay_i = '0;
    logic signed [15:0] thresh_static_i = '0;
    logic               busy_o;
    logic signed [15:0] thresh_eff_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gli_inhibit_unit u_dut (
        .clk(clk), .rst_n(rst_n), .spike_i(spike_i),
        .layer_start_i(layer_start_i), .layer_end_i(layer_end_i),
        .slice_end_i(slice_end_i), .weight_i(weight_i), .decay_i(decay_i),
        .thresh_static_i(thresh_static_i), .busy_o(busy_o),
        .thresh_eff_o(thresh_eff_o)
    );

    // n1, n2 spikes; weight; decay; static threshold; threshold after slice 1 and 2
    typedef struct packed {
        int n1; int n2; int w; int d; int st; int e1; int e2;
    } vec_t;
    localparam vec_t VECS [0:4] = '{
        '{5,  3, 10,  128,   100,   150,   155},
        '{7,  0,  9,  200,   -50,    13,    -1},
        '{0,  4, 100, 255,     0,     0,   400},
        '{20, 10, 50,  64,  1000,  2000,  1750},
        '{1,  1, 255,   0, -1000,  -745,  -745}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic spikes(input int n);
        for (int i = 0; i < n; i++) begin
            spike_i = 1'b1;
            @(negedge clk);
        end
        spike_i = 1'b0;
    endtask

    task automatic end_layer();
        layer_end_i = 1'b1;
        @(negedge clk);
        layer_end_i = 1'b0;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic end_slice();
        slice_end_i = 1'b1;
        @(negedge clk);
        slice_end_i = 1'b0;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic start_layer();
        layer_start_i = 1'b1;
        @(negedge clk);
        layer_start_i = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        check("R1 thresh after reset", int'(thresh_eff_o), 0);
        check("R1 busy after reset", int'(busy_o), 0);
        start_layer();
        check("R1 zero potential", int'(thresh_eff_o), 0);

        // Table walk: two slices each, decay then add (R4, R5, R6)
        foreach (VECS[k]) begin
            do_reset();
            weight_i        = 8'(VECS[k].w);
            decay_i         = 8'(VECS[k].d);
            thresh_static_i = 16'(VECS[k].st);
            spikes(VECS[k].n1);
            end_layer();
            end_slice();
            start_layer();
            check($sformatf("R4 vec%0d slice1", k), int'(thresh_eff_o), VECS[k].e1);
            spikes(VECS[k].n2);
            end_layer();
            end_slice();
            start_layer();
            check($sformatf("R5 vec%0d slice2", k), int'(thresh_eff_o), VECS[k].e2);
        end

        // R2: count saturates
        do_reset();
        weight_i = 8'd1; decay_i = 8'd0; thresh_static_i = 16'sd0;
        spikes(1100);
        end_layer(); end_slice(); start_layer();
        check("R2 count saturation", int'(thresh_eff_o), 1023);

        // R3: spike in strobe cycle goes to next layer; busy window
        do_reset();
        weight_i = 8'd10;
        spikes(2);
        spike_i = 1'b1; layer_end_i = 1'b1;
        @(negedge clk);
        spike_i = 1'b0; layer_end_i = 1'b0;
        check("R3 busy cycle 1", int'(busy_o), 1);
        @(negedge clk);
        check("R3 busy cycle 2", int'(busy_o), 1);
        @(negedge clk);
        check("R3 busy released", int'(busy_o), 0);
        end_layer(); end_slice(); start_layer();
        check("R3 count split at strobe", int'(thresh_eff_o), 30);

        // R8, R9: saturation of accumulator, potential and threshold sum
        do_reset();
        weight_i = 8'd255; thresh_static_i = 16'sd100;
        spikes(200);
        end_layer(); end_slice(); start_layer();
        check("R8 R9 saturated threshold", int'(thresh_eff_o), 32767);
        thresh_static_i = -16'sd32768;
        start_layer();
        check("R8 potential at max", int'(thresh_eff_o), -1);

        // R7: strobes ignored while busy
        do_reset();
        weight_i = 8'd4; decay_i = 8'd0; thresh_static_i = 16'sd10;
        spikes(5);
        end_layer(); end_slice(); start_layer();
        check("R6 threshold set", int'(thresh_eff_o), 30);
        thresh_static_i = 16'sd500;
        spikes(3);
        layer_end_i = 1'b1;
        @(negedge clk);
        layer_end_i = 1'b0; layer_start_i = 1'b1; slice_end_i = 1'b1;
        @(negedge clk);
        layer_start_i = 1'b0; slice_end_i = 1'b0;
        check("R7 start ignored while busy", int'(thresh_eff_o), 30);
        @(negedge clk);
        check("R7 threshold still held", int'(thresh_eff_o), 30);
        start_layer();
        check("R7 slice end ignored while busy", int'(thresh_eff_o), 520);
        end_slice(); start_layer();
        check("R4 accumulator moved", int'(thresh_eff_o), 512);

        // R7: layer end wins over simultaneous slice end
        spikes(2);
        layer_end_i = 1'b1; slice_end_i = 1'b1;
        @(negedge clk);
        layer_end_i = 1'b0; slice_end_i = 1'b0;
        @(negedge clk); @(negedge clk);
        start_layer();
        check("R7 simultaneous strobes", int'(thresh_eff_o), 512);
        end_slice(); start_layer();
        check("R7 layer end kept", int'(thresh_eff_o), 508);

        // R6: threshold stays during layer activity
        thresh_static_i = 16'sd0;
        spikes(4);
        end_layer(); end_slice();
        check("R6 threshold held", int'(thresh_eff_o), 508);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule